// File: doc/BRIEF.md
# Power-Good Window Monitor

This block decides whether a regulated supply rail is reported as good. Each clock it compares a digitised output-voltage sample against an acceptance window around the present DAC target. Both values are unsigned integers in millivolts. The window is lopsided: it reaches further below the target than above it. When the target is very low, the lower bound is dropped and only the upper bound is checked. The result drives an enable for an open-drain power-good pin, modelled here as a plain logic level.

Two kinds of events start a mask interval counted in microsecond ticks: a change of the voltage code, and entry into or exit from deeper sleep. While the mask runs, the output keeps the value it had before the event. A fresh event during a running mask restarts the full count. Until the startup sequencer releases the block, the output is held low.

Control is a three-state machine. In `ST_HOLD` the sequencer has not released the block, and the output is forced low. In `ST_EVAL` the output follows the window comparison. In `ST_MASK` the output is frozen and the mask timer counts ticks.

The transitions are:
- `HOLD->EVAL`: release with no event.
- `HOLD->MASK`: release together with an event.
- `EVAL->MASK`: an event.
- `MASK->MASK`: a retrigger.
- `MASK->EVAL`: the last mask tick with no new event.
- `EVAL->HOLD` and `MASK->HOLD`: release withdrawn.

Top module: `pg_window_mon`

## Requirements
- R1: After reset, `pg_en` is 0.
- R2: While `seq_rel` is 0, `pg_en` is 0 on the next clock edge, whatever the sample.
- R3: The upper bound is inclusive. An unmasked, released sample with `sample_mv <= target_mv + 200` passes that bound, and a sample 1 mV higher drives `pg_en` to 0.
- R4: When `target_mv >= 300`, the lower bound is inclusive. `sample_mv >= target_mv - 300` passes, and a sample 1 mV lower drives `pg_en` to 0.
- R5: When `target_mv < 300`, only the upper bound is checked, so any sample down to 0 mV passes.
- R6: A one-cycle pulse on `vid_chg` while released starts a mask of `MASK_US` (default 100) `us_tick` cycles. The edge that captures the pulse and every edge up to and including the one that counts the last tick leave `pg_en` at its pre-event value.
- R7: A pulse on `slp_evt` starts the same mask as R6.
- R8: An event arriving while a mask runs restarts the full `MASK_US` count from the edge that captures it.
- R9: The mask advances only on cycles with `us_tick` high. On the edge after the last tick, `pg_en` again follows the window.
- R10: Events that arrive while `seq_rel` is 0 are ignored. After release with no event, `pg_en` follows the window one edge later.
- R11: While released and unmasked, `pg_en` takes the window result of the inputs sampled at each edge, so it shows one edge after an input change.
- R12: Dropping `seq_rel` during a mask ends the mask, and `pg_en` is 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_mv | input | MV_W | Digitised output voltage, mV |
| target_mv | input | MV_W | DAC target voltage, mV |
| vid_chg | input | 1 | One-cycle pulse on a voltage-code change |
| slp_evt | input | 1 | One-cycle pulse on deeper-sleep entry or exit |
| seq_rel | input | 1 | Startup sequencer release; 0 forces output low |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| pg_en | output | 1 | Power-good enable, 1 = good |

## Verification
Each window result shows on `pg_en` exactly one edge after the inputs it depends on, because the output is registered and no other stage sits in the path. After an event is captured at edge E0 with ticks present every cycle, the output stays frozen through edge E0+`MASK_US`. The window result appears at edge E0+`MASK_US`+1. The bench drives inputs and samples outputs two nanoseconds after each rising edge, and counts edges from the capturing edge. It checks the last frozen edge and the first updated edge separately, so an off-by-one in either direction is reported. Retrigger and tick-gating scenarios shift E0 or stretch the wall-clock time without changing that edge arithmetic.

// File: rtl/pg_pkg.sv
package pg_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_EVAL = 2'd1,
        ST_MASK = 2'd2
    } pg_state_t;
endpackage

// File: rtl/pg_window_cmp.sv
module pg_window_cmp #(
    parameter int MV_W      = 12,
    parameter int LOW_SPAN  = 300,
    parameter int HIGH_SPAN = 200,
    parameter int LOW_FLOOR = 300
) (
    input  logic [MV_W-1:0] sample_mv,
    input  logic [MV_W-1:0] target_mv,
    output logic            in_win
);
    localparam int EW = MV_W + 1;

    logic [EW-1:0] samp_x;
    logic [EW-1:0] targ_x;
    logic [EW-1:0] hi_lim;
    logic [EW-1:0] lo_lim;
    logic          lo_used;
    logic          hi_ok;
    logic          lo_ok;

    always_comb begin
        samp_x  = {1'b0, sample_mv};
        targ_x  = {1'b0, target_mv};
        hi_lim  = targ_x + EW'(HIGH_SPAN);
        lo_used = (targ_x >= EW'(LOW_FLOOR));
        lo_lim  = lo_used ? (targ_x - EW'(LOW_SPAN)) : '0;
        hi_ok   = (samp_x <= hi_lim);
        lo_ok   = !lo_used || (samp_x >= lo_lim);
        in_win  = hi_ok && lo_ok;
    end
endmodule

// File: rtl/pg_mask_timer.sv
module pg_mask_timer #(
    parameter int MASK_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic tick,
    output logic busy,
    output logic expire
);
    localparam int CW = $clog2(MASK_US + 1);
    localparam logic [CW-1:0] FULL = CW'(MASK_US);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= FULL;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy   = (cnt_q != '0);
    assign expire = tick && !load && !clr && (cnt_q == CW'(1));
endmodule

// File: rtl/pg_window_mon.sv
module pg_window_mon
    import pg_pkg::*;
#(
    parameter int MV_W      = 12,
    parameter int LOW_SPAN  = 300,
    parameter int HIGH_SPAN = 200,
    parameter int LOW_FLOOR = 300,
    parameter int MASK_US   = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MV_W-1:0] sample_mv,
    input  logic [MV_W-1:0] target_mv,
    input  logic            vid_chg,
    input  logic            slp_evt,
    input  logic            seq_rel,
    input  logic            us_tick,
    output logic            pg_en
);
    pg_state_t state_q;
    pg_state_t state_d;
    logic      in_win;
    logic      mask_evt;
    logic      mask_busy;
    logic      mask_expire;
    logic      pg_q;
    logic      pg_d;

    assign mask_evt = vid_chg || slp_evt;

    pg_window_cmp #(
        .MV_W(MV_W), .LOW_SPAN(LOW_SPAN),
        .HIGH_SPAN(HIGH_SPAN), .LOW_FLOOR(LOW_FLOOR)
    ) u_cmp (
        .sample_mv(sample_mv),
        .target_mv(target_mv),
        .in_win(in_win)
    );

    pg_mask_timer #(.MASK_US(MASK_US)) u_tmr (
        .clk(clk),
        .rst_n(rst_n),
        .clr(!seq_rel),
        .load(seq_rel && mask_evt),
        .tick(us_tick),
        .busy(mask_busy),
        .expire(mask_expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (seq_rel) state_d = mask_evt ? ST_MASK : ST_EVAL;
            end
            ST_EVAL: begin
                if (!seq_rel)     state_d = ST_HOLD;
                else if (mask_evt) state_d = ST_MASK;
            end
            ST_MASK: begin
                if (!seq_rel)         state_d = ST_HOLD;
                else if (mask_evt)    state_d = ST_MASK;
                else if (mask_expire) state_d = ST_EVAL;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // output decision
    always_comb begin
        pg_d = 1'b0;
        if (seq_rel) begin
            if (mask_evt) begin
                pg_d = pg_q;
            end else begin
                unique case (state_q)
                    ST_HOLD: pg_d = in_win;
                    ST_EVAL: pg_d = in_win;
                    ST_MASK: pg_d = pg_q;
                    default: pg_d = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= 1'b0;
        else        pg_q <= pg_d;
    end

    assign pg_en = pg_q;
endmodule

// File: rtl/pg_window_chk.sv
module pg_window_chk #(
    parameter int MASK_US = 100
) (
    input logic clk,
    input logic rst_n,
    input logic seq_rel,
    input logic vid_chg,
    input logic slp_evt,
    input logic in_win,
    input logic mask_busy,
    input logic pg_en
);
    assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_rel |=> !pg_en);

    assert_vid_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_rel && vid_chg) |=> $stable(pg_en));

    assert_sleep_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_rel && slp_evt) |=> $stable(pg_en));

    assert_mask_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_rel && mask_busy) |=> $stable(pg_en));

    assert_violation_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_rel && !mask_busy && !vid_chg && !slp_evt && !in_win) |=> !pg_en);

    assert_inside_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_rel && !mask_busy && !vid_chg && !slp_evt && in_win) |=> pg_en);

    assert_mask_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_rel |=> !mask_busy);
endmodule

bind pg_window_mon pg_window_chk #(.MASK_US(MASK_US)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .seq_rel(seq_rel),
    .vid_chg(vid_chg),
    .slp_evt(slp_evt),
    .in_win(in_win),
    .mask_busy(mask_busy),
    .pg_en(pg_en)
);

// File: tb/sim_pg_window_mon.sv
module sim_pg_window_mon;
    localparam int MV_W = 12;
    localparam int MASK = 100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [MV_W-1:0] sample_mv = '0;
    logic [MV_W-1:0] target_mv = '0;
    logic            vid_chg = 1'b0;
    logic            slp_evt = 1'b0;
    logic            seq_rel = 1'b0;
    logic            us_tick = 1'b0;
    logic            pg_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pg_window_mon #(.MV_W(MV_W), .MASK_US(MASK)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_mv(sample_mv), .target_mv(target_mv),
        .vid_chg(vid_chg), .slp_evt(slp_evt), .seq_rel(seq_rel),
        .us_tick(us_tick), .pg_en(pg_en)
    );

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (pg_en !== exp) begin
            n_fail++;
            $display("FAIL %s: pg_en=%b expected=%b at %0t", req, pg_en, exp, $time);
        end
    endtask

    task automatic set_in(input int t, input int s);
        target_mv = MV_W'(t);
        sample_mv = MV_W'(s);
    endtask

    // get to released, unmasked, pg high
    task automatic settle_good();
        seq_rel = 1'b1; us_tick = 1'b1;
        set_in(1000, 1000);
        cyc(MASK + 3);
    endtask

    task automatic t_reset();
        chk("R1", 1'b0);
    endtask

    task automatic t_hold();
        seq_rel = 1'b0; set_in(1000, 1000);
        cyc(5);
        chk("R2 hold with good sample", 1'b0);
        vid_chg = 1'b1; cyc(1); vid_chg = 1'b0;
        slp_evt = 1'b1; cyc(1); slp_evt = 1'b0;
        cyc(2);
        chk("R10 still low in hold", 1'b0);
        seq_rel = 1'b1; cyc(1);
        chk("R10 release follows window one edge later", 1'b1);
    endtask

    task automatic t_upper();
        settle_good();
        set_in(1000, 1200); cyc(1); chk("R3 at upper bound", 1'b1);
        set_in(1000, 1201); cyc(1); chk("R3 above upper bound", 1'b0);
        set_in(1000, 1100); cyc(1); chk("R11 back inside", 1'b1);
    endtask

    task automatic t_lower();
        set_in(1000, 700); cyc(1); chk("R4 at lower bound", 1'b1);
        set_in(1000, 699); cyc(1); chk("R4 below lower bound", 1'b0);
        set_in(301, 0);    cyc(1); chk("R4 target 301 sample 0", 1'b0);
        set_in(301, 1);    cyc(1); chk("R4 target 301 sample 1", 1'b1);
    endtask

    task automatic t_lowtarget();
        set_in(250, 0);   cyc(1); chk("R5 target 250 sample 0", 1'b1);
        set_in(299, 0);   cyc(1); chk("R5 target 299 sample 0", 1'b1);
        set_in(250, 450); cyc(1); chk("R5 upper at 450", 1'b1);
        set_in(250, 451); cyc(1); chk("R5 upper exceeded", 1'b0);
    endtask

    task automatic t_vid_mask();
        settle_good();
        set_in(1000, 1500); vid_chg = 1'b1; cyc(1); vid_chg = 1'b0;
        chk("R6 capture edge holds", 1'b1);
        cyc(MASK);
        chk("R6 last masked edge holds", 1'b1);
        cyc(1);
        chk("R6 first unmasked edge", 1'b0);
        // low value frozen through mask
        set_in(1000, 1000); vid_chg = 1'b1; cyc(1); vid_chg = 1'b0;
        cyc(MASK);
        chk("R6 low value frozen", 1'b0);
        cyc(1);
        chk("R6 recovers after mask", 1'b1);
    endtask

    task automatic t_sleep_mask();
        settle_good();
        set_in(1000, 100); slp_evt = 1'b1; cyc(1); slp_evt = 1'b0;
        cyc(MASK);
        chk("R7 sleep mask holds", 1'b1);
        cyc(1);
        chk("R7 sleep mask ends", 1'b0);
    endtask

    task automatic t_retrigger();
        settle_good();
        set_in(1000, 1500); vid_chg = 1'b1; cyc(1); vid_chg = 1'b0;
        cyc(59);
        slp_evt = 1'b1; cyc(1); slp_evt = 1'b0;
        cyc(MASK);
        chk("R8 held full count after retrigger", 1'b1);
        cyc(1);
        chk("R8 released after restarted count", 1'b0);
    endtask

    task automatic t_tick_gate();
        settle_good();
        us_tick = 1'b0;
        set_in(1000, 1500); vid_chg = 1'b1; cyc(1); vid_chg = 1'b0;
        cyc(3 * MASK);
        chk("R9 no ticks keeps mask", 1'b1);
        us_tick = 1'b1;
        cyc(MASK);
        chk("R9 mask until last tick", 1'b1);
        cyc(1);
        chk("R9 follows window after last tick", 1'b0);
    endtask

    task automatic t_drop();
        settle_good();
        vid_chg = 1'b1; cyc(1); vid_chg = 1'b0;
        cyc(10);
        seq_rel = 1'b0; cyc(1);
        chk("R12 drop during mask forces low", 1'b0);
        seq_rel = 1'b1; cyc(1);
        chk("R12 mask cleared on re-release", 1'b1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #3;
        t_reset();
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 after reset release", 1'b0);
        t_hold();
        t_upper();
        t_lower();
        t_lowtarget();
        t_vid_mask();
        t_sleep_mask();
        t_retrigger();
        t_tick_gate();
        t_drop();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule